// File: doc/BRIEF.md
# Dual-Channel Parallel Converter Load Sequencer

This block sits on the host side of a converter device that holds two 12-bit data registers, channel A and channel B, behind one shared parallel bus. That bus has a 12-bit data path, an active-low select per channel and one active-low write strobe. A register takes the bus value on the rising edge of the write strobe while its own select is low. If both selects are low, one edge loads both channels with the same value.

A client hands the block a 12-bit code and a 2-bit target through a valid/ready handshake. The block then plays out the bus waveform. Each phase is sized in system clock cycles from nanosecond limits given as parameters. Each phase length is rounded up and is never shorter than one cycle. After the selects are released, the block waits a settling interval so the analog output can settle, and then pulses `done`. A request with no target is consumed and answered with a `reject` pulse. No bus activity takes place for it.

The controller is a state machine with these states:
- `ST_IDLE`: ready.
- `ST_REJECT`: one cycle, after a zero target.
- `ST_SETUP`: selects low, data driven.
- `ST_STROBE`: write low.
- `ST_HOLD`: write high, data and selects kept.
- `ST_SETTLE`: selects released, waiting.
- `ST_DONE`: one cycle.

Its transitions are:
- idle→setup on a valid request with a nonzero target.
- idle→reject on a valid request with target 00.
- reject→idle unconditionally.
- setup→strobe, strobe→hold, hold→settle and settle→done, each when that phase's cycle count runs out.
- done→idle unconditionally.

Top module: `dual_dac_loader`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `dac_wr_n`, `dac_sel_a_n` and `dac_sel_b_n` are 1, `req_ready` is 1, and `done` and `reject` are 0.
- R2: `req_ready` is 1 only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the sequence returns to idle.
- R3: Target encoding: `req_tgt` = 2'b01 drives only `dac_sel_a_n` low, 2'b10 drives only `dac_sel_b_n` low, and 2'b11 drives both low. Only the selected registers of a receiving converter capture the code, and unselected ones keep their value. The write strobe is never low unless at least one select is low.
- R4: A request with `req_tgt` = 2'b00 is consumed. `reject` is 1 for exactly the one cycle after it is taken, and `req_ready` is 0 in that cycle. Selects and the write strobe stay 1 throughout.
- R5: Selects go low and the code appears on `dac_d` in the cycle after acceptance. `dac_wr_n` falls after N_PRE cycles, where N_PRE = max(1, ceil(max(T_DSU_NS, T_SSU_NS)/CLK_NS) − N_PULSE).
- R6: `dac_wr_n` stays low for exactly N_PULSE = max(1, ceil(T_PW_NS/CLK_NS)) cycles.
- R7: After `dac_wr_n` rises, the selects stay low for exactly N_HOLD = max(1, ceil(T_DH_NS/CLK_NS)) cycles, then go high. The selects do not change while `dac_wr_n` is low.
- R8: `dac_d` equals the accepted code and does not change for as long as any select is low.
- R9: `done` rises after exactly N_SETTLE = max(1, ceil(T_SETTLE_NS/CLK_NS)) cycles with the selects high. It is high for one cycle, and `req_ready` is 1 in the following cycle.
- R10: A `req_valid` held high during a sequence, with a different code and target, changes neither the bus waveform nor the loaded value. It starts nothing while it is dropped before idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_code | input | 12 | Code to load |
| req_tgt | input | 2 | Target: 01 A, 10 B, 11 both, 00 invalid |
| dac_d | output | 12 | Shared converter data bus |
| dac_sel_a_n | output | 1 | Channel A select, active low |
| dac_sel_b_n | output | 1 | Channel B select, active low |
| dac_wr_n | output | 1 | Write strobe, active low, loads on rising edge |
| done | output | 1 | One-cycle pulse after settling |
| reject | output | 1 | One-cycle pulse for an invalid target |

## Verification
A wrong state register or a miscounted phase shows up directly at the bus, within the transfer it corrupts. In that case a measured phase length, counted in clock cycles between select, strobe and done edges, differs from its formula. A wrong captured target or code shows up as a register in the bench's converter model holding the wrong value at the strobe's rising edge. It can also show up as a select low for a channel that was not addressed. An FSM that fails to leave a busy state, or that leaves it too early, shows up as `req_ready` or `done` at the wrong cycle. It can also show up as a second waveform starting from a request held during a busy period.

// File: rtl/dal_pkg.sv
package dal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_SETTLE,
        ST_DONE
    } dal_state_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_A    = 2'b01,
        TGT_B    = 2'b10,
        TGT_BOTH = 2'b11
    } dal_tgt_t;

    // ceiling of ns/period, never below one cycle
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dal_phase_timer.sv
module dal_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dal_pin_drive.sv
module dal_pin_drive
    import dal_pkg::*;
#(
    parameter int DW = 12
) (
    input  dal_state_t      state,
    input  logic [1:0]      tgt_q,
    input  logic [DW-1:0]   code_q,
    output logic [DW-1:0]   dac_d,
    output logic            sel_a_n,
    output logic            sel_b_n,
    output logic            wr_n,
    output logic            ready,
    output logic            done,
    output logic            reject
);
    always_comb begin
        dac_d   = '0;
        sel_a_n = 1'b1;
        sel_b_n = 1'b1;
        wr_n    = 1'b1;
        ready   = 1'b0;
        done    = 1'b0;
        reject  = 1'b0;
        unique case (state)
            ST_IDLE:   ready  = 1'b1;
            ST_REJECT: reject = 1'b1;
            ST_SETUP, ST_STROBE, ST_HOLD: begin
                dac_d   = code_q;
                sel_a_n = ~tgt_q[0];
                sel_b_n = ~tgt_q[1];
                wr_n    = (state != ST_STROBE);
            end
            ST_SETTLE: ;
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dal_pkg::*;
#(
    parameter int DW          = 12,
    parameter int CLK_NS      = 10,
    parameter int T_DSU_NS    = 80,
    parameter int T_DH_NS     = 25,
    parameter int T_SSU_NS    = 100,
    parameter int T_PW_NS     = 100,
    parameter int T_SETTLE_NS = 1500
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [DW-1:0] req_code,
    input  logic [1:0]    req_tgt,
    output logic [DW-1:0] dac_d,
    output logic          dac_sel_a_n,
    output logic          dac_sel_b_n,
    output logic          dac_wr_n,
    output logic          done,
    output logic          reject
);
    localparam int N_PULSE  = ns_to_cyc(T_PW_NS, CLK_NS);
    localparam int N_PRE    = imax(1, ns_to_cyc(imax(T_DSU_NS, T_SSU_NS), CLK_NS) - N_PULSE);
    localparam int N_HOLD   = ns_to_cyc(T_DH_NS, CLK_NS);
    localparam int N_SETTLE = ns_to_cyc(T_SETTLE_NS, CLK_NS);
    localparam int N_MAX    = imax(imax(N_PULSE, N_PRE), imax(N_HOLD, N_SETTLE));
    localparam int CW       = imax(1, $clog2(N_MAX + 1));

    dal_state_t    state, nxt;
    logic [1:0]    tgt_q;
    logic [DW-1:0] code_q;
    logic          tmr_load, tmr_expired;
    logic [CW-1:0] tmr_val;
    logic          accept;

    assign accept = (state == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= '0;
            code_q <= '0;
        end else if (accept) begin
            tgt_q  <= req_tgt;
            code_q <= req_code;
        end
    end

    // next state and phase length
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                if (req_tgt == TGT_NONE) begin
                    nxt = ST_REJECT;
                end else begin
                    nxt      = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(N_PRE - 1);
                end
            end
            ST_REJECT: nxt = ST_IDLE;
            ST_SETUP: if (tmr_expired) begin
                nxt      = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = CW'(N_PULSE - 1);
            end
            ST_STROBE: if (tmr_expired) begin
                nxt      = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CW'(N_HOLD - 1);
            end
            ST_HOLD: if (tmr_expired) begin
                nxt      = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = CW'(N_SETTLE - 1);
            end
            ST_SETTLE: if (tmr_expired) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    dal_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dal_pin_drive #(.DW(DW)) u_drive (
        .state   (state),
        .tgt_q   (tgt_q),
        .code_q  (code_q),
        .dac_d   (dac_d),
        .sel_a_n (dac_sel_a_n),
        .sel_b_n (dac_sel_b_n),
        .wr_n    (dac_wr_n),
        .ready   (req_ready),
        .done    (done),
        .reject  (reject)
    );

    // R1: reset leaves the bus released and the block ready
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (dac_wr_n && dac_sel_a_n && dac_sel_b_n && req_ready && !done && !reject));

    // R2: ready only while the bus is quiet
    p_ready_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (dac_wr_n && dac_sel_a_n && dac_sel_b_n));

    // R3: strobe only under a select
    p_strobe_selected_r3: assert property (@(posedge clk) disable iff (rst)
        !dac_wr_n |-> (!dac_sel_a_n || !dac_sel_b_n));

    // R4: rejection keeps the bus idle
    p_reject_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        reject |-> (dac_wr_n && dac_sel_a_n && dac_sel_b_n && !req_ready));

    // R7: selects unchanged across the strobe's rising edge
    p_sel_held_r7: assert property (@(posedge clk) disable iff (rst)
        !dac_wr_n |=> ($stable(dac_sel_a_n) && $stable(dac_sel_b_n)));

    // R8: data frozen while selected
    p_data_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        ((!dac_sel_a_n || !dac_sel_b_n) && !$past(dac_sel_a_n && dac_sel_b_n)) |-> $stable(dac_d));

    // R9: done lasts one cycle and is followed by ready
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

endmodule

// File: tb/dual_dac_loader_test.sv
module dual_dac_loader_test;
    localparam int DW = 12, CLK_NS = 10, T_DSU = 80, T_DH = 25,
                   T_SSU = 100, T_PW = 100, T_SET = 1500;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_PULSE  = cyc(T_PW);
    localparam int E_PRE0   = cyc((T_DSU > T_SSU) ? T_DSU : T_SSU) - E_PULSE;
    localparam int E_PRE    = (E_PRE0 < 1) ? 1 : E_PRE0;
    localparam int E_HOLD   = cyc(T_DH);
    localparam int E_SETTLE = cyc(T_SET);

    logic clk = 0, rst = 1;
    logic req_valid = 0;
    logic [DW-1:0] req_code = '0;
    logic [1:0] req_tgt = '0;
    logic req_ready, dac_sel_a_n, dac_sel_b_n, dac_wr_n, done, reject;
    logic [DW-1:0] dac_d;

    int n_total = 0, n_fail = 0;
    logic [DW-1:0] mdl_a = '0, mdl_b = '0, exp_a = '0, exp_b = '0;

    always #5 clk = ~clk;

    dual_dac_loader #(.DW(DW), .CLK_NS(CLK_NS), .T_DSU_NS(T_DSU), .T_DH_NS(T_DH),
        .T_SSU_NS(T_SSU), .T_PW_NS(T_PW), .T_SETTLE_NS(T_SET)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_code(req_code), .req_tgt(req_tgt), .dac_d(dac_d),
        .dac_sel_a_n(dac_sel_a_n), .dac_sel_b_n(dac_sel_b_n),
        .dac_wr_n(dac_wr_n), .done(done), .reject(reject));

    // receiving converter model: load on rising strobe edge
    always @(posedge dac_wr_n) begin
        if (!rst) begin
            if (dac_sel_a_n === 1'b0) mdl_a <= dac_d;
            if (dac_sel_b_n === 1'b0) mdl_b <= dac_d;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        check(dac_wr_n === 1 && dac_sel_a_n === 1 && dac_sel_b_n === 1, "R1 bus in reset",
              {dac_wr_n, dac_sel_a_n, dac_sel_b_n}, 7);
        check(req_ready === 1 && done === 0 && reject === 0, "R1 flags in reset",
              {req_ready, done, reject}, 4);
        rst = 0;
        @(negedge clk);
        check(dac_wr_n === 1 && dac_sel_a_n === 1 && dac_sel_b_n === 1 && req_ready === 1,
              "R1 after release", {dac_wr_n, dac_sel_a_n, dac_sel_b_n, req_ready}, 15);
    endtask

    task automatic t_load(input logic [DW-1:0] code, input logic [1:0] tgt, input bit poke);
        int pre, pulse, hold, settle;
        bit bad;
        @(negedge clk);
        check(req_ready === 1, "R2 ready before request", req_ready, 1);
        req_valid = 1; req_code = code; req_tgt = tgt;
        @(negedge clk);
        if (poke) begin
            req_code = ~code; req_tgt = 2'b11;
        end else begin
            req_valid = 0;
        end
        check(req_ready === 0, "R2 busy after accept", req_ready, 0);
        check(dac_sel_a_n === ~tgt[0] && dac_sel_b_n === ~tgt[1], "R3 select decode",
              {dac_sel_b_n, dac_sel_a_n}, {~tgt[1], ~tgt[0]});
        check(dac_d === code, "R8 code on bus", dac_d, code);
        bad = 0; pre = 0; pulse = 0; hold = 0; settle = 0;
        while (dac_wr_n === 1'b1) begin
            pre++;
            if (dac_d !== code) bad = 1;
            @(negedge clk);
        end
        while (dac_wr_n === 1'b0) begin
            pulse++;
            if (dac_d !== code || dac_sel_a_n !== ~tgt[0] || dac_sel_b_n !== ~tgt[1]) bad = 1;
            @(negedge clk);
        end
        while (dac_sel_a_n === 1'b0 || dac_sel_b_n === 1'b0) begin
            hold++;
            if (dac_d !== code || req_ready !== 0) bad = 1;
            @(negedge clk);
        end
        while (done !== 1'b1) begin
            settle++;
            if (dac_wr_n !== 1) bad = 1;
            @(negedge clk);
        end
        req_valid = 0;
        check(pre == E_PRE, "R5 setup cycles", pre, E_PRE);
        check(pulse == E_PULSE, "R6 strobe width", pulse, E_PULSE);
        check(hold == E_HOLD, "R7 hold cycles", hold, E_HOLD);
        check(!bad, "R8 bus stable during access", bad, 0);
        check(settle == E_SETTLE, "R9 settle cycles", settle, E_SETTLE);
        @(negedge clk);
        check(done === 0 && req_ready === 1, "R9 done single, ready back", {done, req_ready}, 1);
        if (tgt[0]) exp_a = code;
        if (tgt[1]) exp_b = code;
        check(mdl_a === exp_a, "R3 channel A content", mdl_a, exp_a);
        check(mdl_b === exp_b, "R3 channel B content", mdl_b, exp_b);
        if (poke) begin
            repeat (3) @(negedge clk);
            check(dac_sel_a_n === 1 && dac_sel_b_n === 1 && dac_wr_n === 1 && req_ready === 1,
                  "R10 busy request not replayed",
                  {dac_sel_a_n, dac_sel_b_n, dac_wr_n, req_ready}, 15);
        end
    endtask

    task automatic t_reject();
        @(negedge clk);
        req_valid = 1; req_code = 12'hABC; req_tgt = 2'b00;
        @(negedge clk);
        req_valid = 0;
        check(reject === 1 && req_ready === 0, "R4 reject pulse", {reject, req_ready}, 2);
        check(dac_wr_n === 1 && dac_sel_a_n === 1 && dac_sel_b_n === 1, "R4 bus quiet",
              {dac_wr_n, dac_sel_a_n, dac_sel_b_n}, 7);
        @(negedge clk);
        check(reject === 0 && req_ready === 1, "R4 reject single cycle", {reject, req_ready}, 1);
        check(mdl_a === exp_a && mdl_b === exp_b, "R4 registers untouched", mdl_a, exp_a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_load(12'h5A3, 2'b01, 0);
        t_load(12'h0F0, 2'b10, 0);
        t_load(12'hFFF, 2'b11, 0);
        t_load(12'h000, 2'b01, 0);
        t_reject();
        t_load(12'h123, 2'b10, 1);
        t_load(12'h800, 2'b11, 0);
        finish_run();
    end

endmodule